// File: doc/BRIEF.md
# MSI Doorbell Window Decoder

This block sits behind a memory-mapped write window that PCI devices target to raise message-signalled interrupts. The window is split into equal per-device slots. A write into the window is decoded into a slot index, taken from the upper offset bits, and a vector number, formed by ORing the word index within the slot with the written data. One handler covers both message styles. An MSI-X device encodes its vector in the address and writes zero. An MSI device writes to the slot base and puts its vector in the low data bits.

Each slot has a table entry that holds a configuration-space address, a base interrupt number and a vector count. Software fills these entries through a side programming port. For every write that lands inside the window, the block emits a single-cycle interrupt strobe. The strobe carries the slot's base number plus the decoded vector. Reads of the window return zero and have no effect.

Top module: `msi_doorbell`

## Requirements
- R1: After reset `irqValid` is 0 and every table entry reads back as zero (configuration address, base and count) on the `tblCur*` outputs.
- R2: A cycle with `tblWrEn` high writes the configuration address, base and count into entry `tblSlot`, all in that one cycle. The `tblCur*` outputs show the entry selected by `tblSlot` combinationally.
- R3: For a window write, the slot is byte offset bits [20:16]. The vector is offset bits [15:2], zero-extended, bitwise ORed with the 32-bit write data. Data bit 0 is the least significant bit of byte lane 0 (little-endian).
- R4: An accepted write raises `irqValid` for exactly one clock, in the cycle after the write. `irqNum` in that cycle equals the slot base plus the vector, modulo 2^32.
- R5: An MSI-X style write (data zero) yields a vector taken from the address alone.
- R6: An MSI style write to the slot base (offset bits [15:2] zero) yields a vector equal to the data.
- R7: A write whose offset is 0x200000 or above (outside the 32 slots of 64 KiB) produces no strobe.
- R8: `busRdData` is always zero. A read produces no strobe.
- R9: Writes on consecutive cycles each produce their own strobe, in order.
- R10: When a table write and a window write to the same slot share a cycle, the strobe uses the base held before that table write. Later writes use the new base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Window write strobe |
| busRdEn | input | 1 | Window read strobe |
| busAddr | input | 24 | Byte offset into the window |
| busWrData | input | 32 | Write data, little-endian |
| busRdData | output | 32 | Read data, always zero |
| tblWrEn | input | 1 | Table entry write strobe |
| tblSlot | input | 5 | Table entry index for programming and readback |
| tblCfgAddr | input | 32 | Configuration-space address to store |
| tblBaseIrq | input | 32 | Base interrupt number to store |
| tblVecCnt | input | 8 | Vector count to store |
| tblCurCfg | output | 32 | Stored configuration address of entry `tblSlot` |
| tblCurBase | output | 32 | Stored base interrupt number of entry `tblSlot` |
| tblCurCnt | output | 8 | Stored vector count of entry `tblSlot` |
| irqValid | output | 1 | One-cycle interrupt strobe |
| irqNum | output | 32 | Interrupt number carried with the strobe |

## Verification
Table programming and a doorbell write can land in the same cycle on the same slot. The bench drives both in one cycle. It expects the strobe to carry the old base plus the vector, then sends a second doorbell to check that the new base has taken effect. A window read is also issued in the same cycle as a write, to show that the read neither blocks the strobe nor adds one.

// File: rtl/msi_pkg.sv
package msi_pkg;
  // Strobes passed from control to datapath
  typedef struct packed {
    logic fire;   // accepted window write: compute and emit interrupt
    logic load;   // program the addressed table entry
  } msiCtl_t;
endpackage

// File: rtl/msi_ctrl.sv
module msi_ctrl
  import msi_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int WIN_W  = 21
) (
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              tblWrEn,
  output msiCtl_t           ctl
);
  logic inWindow;

  // Offsets beyond the last slot have non-zero bits above the window
  assign inWindow = (busAddr[ADDR_W-1:WIN_W] == '0);

  always_comb begin
    ctl.fire = busWrEn && inWindow;
    ctl.load = tblWrEn;
  end
endmodule

// File: rtl/msi_datapath.sv
module msi_datapath
  import msi_pkg::*;
#(
  parameter int NUM_SLOTS  = 32,
  parameter int SLOT_SHIFT = 16,
  parameter int ADDR_W     = 24,
  parameter int DATA_W     = 32,
  parameter int IRQ_W      = 32,
  parameter int CFG_W      = 32,
  parameter int CNT_W      = 8,
  localparam int SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  msiCtl_t           ctl,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic [SLOT_W-1:0] tblSlot,
  input  logic [CFG_W-1:0]  tblCfgAddr,
  input  logic [IRQ_W-1:0]  tblBaseIrq,
  input  logic [CNT_W-1:0]  tblVecCnt,
  output logic [CFG_W-1:0]  tblCurCfg,
  output logic [IRQ_W-1:0]  tblCurBase,
  output logic [CNT_W-1:0]  tblCurCnt,
  output logic              irqValid,
  output logic [IRQ_W-1:0]  irqNum
);
  localparam int IDX_W = SLOT_SHIFT - 2;

  logic [CFG_W-1:0] cfgMem  [NUM_SLOTS];
  logic [IRQ_W-1:0] baseMem [NUM_SLOTS];
  logic [CNT_W-1:0] cntMem  [NUM_SLOTS];

  logic [SLOT_W-1:0] slotIdx;
  logic [IDX_W-1:0]  wordIdx;
  logic [DATA_W-1:0] vecNum;
  logic [IRQ_W-1:0]  sumNum;

  // One register bank per slot, each with its own write decode
  for (genvar g = 0; g < NUM_SLOTS; g++) begin : gSlot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        cfgMem[g]  <= '0;
        baseMem[g] <= '0;
        cntMem[g]  <= '0;
      end else if (ctl.load && (tblSlot == SLOT_W'(g))) begin
        cfgMem[g]  <= tblCfgAddr;
        baseMem[g] <= tblBaseIrq;
        cntMem[g]  <= tblVecCnt;
      end
    end
  end

  assign tblCurCfg  = cfgMem[tblSlot];
  assign tblCurBase = baseMem[tblSlot];
  assign tblCurCnt  = cntMem[tblSlot];

  // Address carries slot and word index; data ORs into the vector
  assign slotIdx = busAddr[SLOT_SHIFT +: SLOT_W];
  assign wordIdx = busAddr[SLOT_SHIFT-1:2];
  assign vecNum  = DATA_W'(wordIdx) | busWrData;
  assign sumNum  = baseMem[slotIdx] + IRQ_W'(vecNum);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqValid <= 1'b0;
      irqNum   <= '0;
    end else begin
      irqValid <= ctl.fire;
      if (ctl.fire) irqNum <= sumNum;
    end
  end
endmodule

// File: rtl/msi_doorbell.sv
module msi_doorbell
  import msi_pkg::*;
#(
  parameter int NUM_SLOTS  = 32,
  parameter int SLOT_SHIFT = 16,
  parameter int ADDR_W     = 24,
  parameter int DATA_W     = 32,
  parameter int IRQ_W      = 32,
  parameter int CFG_W      = 32,
  parameter int CNT_W      = 8,
  localparam int SLOT_W    = $clog2(NUM_SLOTS),
  localparam int WIN_W     = SLOT_SHIFT + SLOT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic              tblWrEn,
  input  logic [SLOT_W-1:0] tblSlot,
  input  logic [CFG_W-1:0]  tblCfgAddr,
  input  logic [IRQ_W-1:0]  tblBaseIrq,
  input  logic [CNT_W-1:0]  tblVecCnt,
  output logic [CFG_W-1:0]  tblCurCfg,
  output logic [IRQ_W-1:0]  tblCurBase,
  output logic [CNT_W-1:0]  tblCurCnt,
  output logic              irqValid,
  output logic [IRQ_W-1:0]  irqNum
);
  msiCtl_t ctl;
  logic    unusedBits;

  // Reads are undefined for a doorbell window: answer zero, touch nothing
  assign busRdData  = '0;
  assign unusedBits = ^{busRdEn, busAddr[1:0]};

  msi_ctrl #(.ADDR_W(ADDR_W), .WIN_W(WIN_W)) uCtrl (
    .busWrEn (busWrEn),
    .busAddr (busAddr),
    .tblWrEn (tblWrEn),
    .ctl     (ctl)
  );

  msi_datapath #(
    .NUM_SLOTS(NUM_SLOTS), .SLOT_SHIFT(SLOT_SHIFT), .ADDR_W(ADDR_W),
    .DATA_W(DATA_W), .IRQ_W(IRQ_W), .CFG_W(CFG_W), .CNT_W(CNT_W)
  ) uData (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .busAddr    (busAddr),
    .busWrData  (busWrData),
    .tblSlot    (tblSlot),
    .tblCfgAddr (tblCfgAddr),
    .tblBaseIrq (tblBaseIrq),
    .tblVecCnt  (tblVecCnt),
    .tblCurCfg  (tblCurCfg),
    .tblCurBase (tblCurBase),
    .tblCurCnt  (tblCurCnt),
    .irqValid   (irqValid),
    .irqNum     (irqNum)
  );
endmodule

// File: rtl/msi_doorbell_chk.sv
module msi_doorbell_chk #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32,
  parameter int IRQ_W  = 32,
  parameter int SLOT_W = 5,
  parameter int WIN_W  = 21
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWrEn,
  input logic              busRdEn,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busRdData,
  input logic              tblWrEn,
  input logic [SLOT_W-1:0] tblSlot,
  input logic [IRQ_W-1:0]  tblBaseIrq,
  input logic [IRQ_W-1:0]  tblCurBase,
  input logic              irqValid
);
  logic inWin;
  assign inWin = (busAddr[ADDR_W-1:WIN_W] == '0);

  // R1: reset leaves no strobe behind
  a_r1_reset_quiet: assert property (@(posedge clk) !rstN |=> !irqValid);

  // R2: a programmed base is visible on the readback of the same slot
  a_r2_base_stored: assert property (@(posedge clk) disable iff (!rstN)
    tblWrEn |=> (tblSlot != $past(tblSlot)) || (tblCurBase == $past(tblBaseIrq)));

  // R4: an accepted write strobes in the next cycle
  a_r4_strobe_follows: assert property (@(posedge clk) disable iff (!rstN)
    busWrEn && inWin |=> irqValid);

  // R4: every strobe has an accepted write one cycle earlier
  a_r4_strobe_cause: assert property (@(posedge clk) disable iff (!rstN)
    irqValid |-> $past(busWrEn && inWin));

  // R7: an out-of-window write leaves the strobe low
  a_r7_outside_ignored: assert property (@(posedge clk) disable iff (!rstN)
    busWrEn && !inWin |=> !irqValid);

  // R8: reads without writes give no strobe, and read data stays zero
  a_r8_read_silent: assert property (@(posedge clk) disable iff (!rstN)
    busRdEn && !busWrEn |=> !irqValid);

  always_comb begin
    a_r8_read_zero: assert (busRdData == '0);
  end
endmodule

bind msi_doorbell msi_doorbell_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IRQ_W(IRQ_W), .SLOT_W(SLOT_W), .WIN_W(WIN_W)
) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .busWrEn    (busWrEn),
  .busRdEn    (busRdEn),
  .busAddr    (busAddr),
  .busRdData  (busRdData),
  .tblWrEn    (tblWrEn),
  .tblSlot    (tblSlot),
  .tblBaseIrq (tblBaseIrq),
  .tblCurBase (tblCurBase),
  .irqValid   (irqValid)
);

// File: tb/sim_msi_doorbell.sv
`timescale 1ns/1ps
module sim_msi_doorbell;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0, busRdEn = 1'b0;
  logic [23:0] busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        tblWrEn = 1'b0;
  logic [4:0]  tblSlot = '0;
  logic [31:0] tblCfgAddr = '0, tblBaseIrq = '0;
  logic [7:0]  tblVecCnt = '0;
  logic [31:0] tblCurCfg, tblCurBase;
  logic [7:0]  tblCurCnt;
  logic        irqValid;
  logic [31:0] irqNum;

  int checks = 0, errors = 0, pulses = 0;
  logic [31:0] mBase [32];
  logic [31:0] expQ [$];
  string       tagQ [$];

  always #2.5 clk = ~clk;

  msi_doorbell u0 (.*);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pop one expected item per observed strobe
  always @(negedge clk) begin
    if (rstN && irqValid) begin
      pulses++;
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL R4 unexpected strobe actual=%h expected=none", irqNum);
      end else begin
        automatic logic [31:0] e = expQ.pop_front();
        automatic string t = tagQ.pop_front();
        if (irqNum !== e) begin
          errors++;
          $display("FAIL %s irqNum actual=%h expected=%h", t, irqNum, e);
        end
      end
    end
  end

  task automatic prog(int slot, logic [31:0] cfg, logic [31:0] base, logic [7:0] cnt);
    tblWrEn = 1'b1; tblSlot = 5'(slot);
    tblCfgAddr = cfg; tblBaseIrq = base; tblVecCnt = cnt;
    @(negedge clk);
    tblWrEn = 1'b0;
    mBase[slot] = base;
    #0.5;
    check("R2 cfg", tblCurCfg, cfg);
    check("R2 base", tblCurBase, base);
    check("R2 cnt", {24'd0, tblCurCnt}, {24'd0, cnt});
  endtask

  // Driver: one window write, pushes expectation when it lies in the window
  task automatic ring(string tag, logic [23:0] addr, logic [31:0] data);
    busWrEn = 1'b1; busAddr = addr; busWrData = data;
    if (addr < 24'h200000) begin
      expQ.push_back(mBase[addr[20:16]] + ({18'd0, addr[15:2]} | data));
      tagQ.push_back(tag);
    end
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 32; i++) mBase[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 irqValid", {31'd0, irqValid}, 32'd0);
    for (int i = 0; i < 32; i += 7) begin
      tblSlot = 5'(i); #0.5;
      check("R1 entry base", tblCurBase, 32'd0);
      check("R1 entry cfg", tblCurCfg, 32'd0);
    end
    @(negedge clk);
    // R2: programming
    prog(0, 32'h0000_0800, 32'h0000_1000, 8'd4);
    prog(5, 32'h0000_2800, 32'h0000_2000, 8'd16);
    prog(31, 32'h0000_F800, 32'h0000_3000, 8'd32);
    // R5: MSI-X, vector in address
    ring("R5", 24'h05_000C, 32'd0);
    check("R4 pulse high", {31'd0, irqValid}, 32'd1);
    @(negedge clk);
    check("R4 pulse one cycle", {31'd0, irqValid}, 32'd0);
    // R6: MSI, vector in data
    ring("R6", 24'h00_0000, 32'h0000_0007);
    // R3: OR of address index and data
    ring("R3 or", 24'h00_0010, 32'h0000_0003);
    ring("R3 max offset", 24'h1F_FFFC, 32'd0);
    ring("R3 unprogrammed slot", 24'h0A_0020, 32'd0);
    repeat (2) @(negedge clk);
    // R4: modulo-2^32 sum
    prog(31, 32'h0000_F800, 32'hFFFF_FFF0, 8'd32);
    ring("R4 wrap", 24'h1F_0080, 32'd0);
    repeat (2) @(negedge clk);
    // R7: outside window
    begin
      automatic int p0 = pulses;
      ring("R7", 24'h20_0000, 32'd1);
      ring("R7", 24'hFF_FFFC, 32'd0);
      repeat (2) @(negedge clk);
      check("R7 no strobe", 32'(pulses), 32'(p0));
    end
    // R8: reads
    begin
      automatic int p0 = pulses;
      busRdEn = 1'b1; busAddr = 24'h05_0004; #0.5;
      check("R8 read data", busRdData, 32'd0);
      @(negedge clk); busRdEn = 1'b0;
      repeat (2) @(negedge clk);
      check("R8 no strobe", 32'(pulses), 32'(p0));
      // read alongside a write: write still strobes once
      busRdEn = 1'b1;
      ring("R8 read with write", 24'h05_0008, 32'd0);
      busRdEn = 1'b0;
      repeat (2) @(negedge clk);
      check("R8 one strobe", 32'(pulses), 32'(p0 + 1));
    end
    // R9: back-to-back
    begin
      automatic int p0 = pulses;
      ring("R9 a", 24'h00_0004, 32'd0);
      ring("R9 b", 24'h05_0000, 32'h0000_0009);
      ring("R9 c", 24'h00_0004, 32'd0);
      ring("R9 d", 24'h1F_0000, 32'h0000_0001);
      repeat (2) @(negedge clk);
      check("R9 count", 32'(pulses), 32'(p0 + 4));
    end
    // R10: table write and doorbell same cycle, same slot
    tblWrEn = 1'b1; tblSlot = 5'd5; tblCfgAddr = 32'h0; tblBaseIrq = 32'h0000_9000; tblVecCnt = 8'd2;
    ring("R10 old base", 24'h05_0004, 32'd0);
    tblWrEn = 1'b0;
    mBase[5] = 32'h0000_9000;
    ring("R10 new base", 24'h05_0004, 32'd0);
    repeat (3) @(negedge clk);
    check("R9 queue drained", 32'(expQ.size()), 32'd0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule